// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block generates the raster timing for one parallel LCD channel. It runs on the pixel clock and keeps a pixel counter and a line counter. From these it produces horizontal sync, vertical sync and a data-enable strobe, and it also outputs the current pixel and line position. Software programs the block over a simple 32-bit word-addressed register bus. The programmed values are the active size, the line and frame totals, the back porches, the sync widths, the sync polarities and a start delay. Timing starts only when both a global enable and a channel enable are set.

Timing values are stored as minus-one fields. The frame total is stored as a half-line count. Each back porch is counted from the start of its sync pulse, so it includes the sync width. A timing write goes into a shadow copy that is loaded at the start of a frame, so a frame already in progress is never altered.

The block has two interrupt flags:
- A vertical-blank flag, which sets when the active area ends.
- A line-match flag, which sets on a programmed line.

Each flag has its own enable. A flag is cleared by writing a zero to its bit, and writing a one keeps it.

Top module: `lcd_tgen`

## Requirements
- R1: After reset all enables, flags and registers read zero. hsync, vsync, de, both irq outputs, pix_x and pix_y are all low.
- R2: Register 5 holds {line total − 1, back porch − 1} in bits [31:16] and [15:0]. Register 6 holds {2 × frame lines, vertical back porch − 1}. While running, pix_x counts 0 to line total − 1, and pix_y advances at each pix_x wrap, from 0 to frame lines − 1.
- R3: Register 4 holds {width − 1, height − 1}. de is high exactly when pix_x < width and pix_y < height while running.
- R4: Register 7 holds {hsync width − 1, vsync width − 1}. Before polarity, hsync is active for pix_x from (line total − back porch) up to but not including (line total − back porch + hsync width).
- R5: Before polarity, vsync is active for pix_y from (frame lines − vertical back porch) up to but not including that value plus the vsync width.
- R6: Register 0 bit 31 is the global enable. Register 3 has the channel enable in bit 31 and a start delay in bits 8:4. The raster starts (pix 0,0) 1 + delay × line total clocks after the write that completes the enable pair, and all outputs stay inactive until then. A delay field above 30 acts as 30.
- R7: Register 1 bit 15 is the vertical-blank flag and bit 31 its enable. The flag sets in the first clock with pix_x = 0 and pix_y = height. vblank_irq equals the flag AND the enable.
- R8: Writing register 1 with a flag bit at 0 clears that flag. Writing it with the bit at 1 leaves the flag unchanged.
- R9: Register 8 bit 25 inverts hsync and bit 24 inverts vsync. The inactive level is therefore the bit's value, and outputs sit there whenever the raster is not running.
- R10: Register 2 bits 11:0 hold a line number L. Register 1 bit 14 is the line-match flag and bit 30 its enable. The flag sets in the first clock with pix_x = 0 and pix_y = L. line_irq equals the flag AND the enable.
- R11: A timing register written during a frame leaves that frame's timing unchanged. The new value applies from the next frame start.
- R12: Clearing the channel enable stops the raster at once. From the clock after the write, de is low, pix_x and pix_y are 0, and the syncs are at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable |
| pix_x | output | CNT_W | Pixel position in line |
| pix_y | output | CNT_W | Line position in frame |
| vblank_irq | output | 1 | Vertical-blank interrupt |
| line_irq | output | 1 | Line-match interrupt |

## Verification
The bench builds the block with its default parameters: 12-bit counters, a 5-bit delay field and a clamp limit of 30. The delay field can therefore hold 31, which reaches the clamp. The bench uses frames of only a few hundred pixels. This lets each random configuration be checked on every clock across two full frames, including the start-delay lead-in. It also makes the 30-line clamp reachable in a few hundred cycles. Together these bring flag timing, polarity and mid-frame reprogramming within reach in a short run.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
   // register word indices
   localparam int unsigned RA_GLOBAL = 0;
   localparam int unsigned RA_IRQ    = 1;
   localparam int unsigned RA_LINE   = 2;
   localparam int unsigned RA_CHAN   = 3;
   localparam int unsigned RA_TIM0   = 4;  // active, horizontal, vertical, sync widths follow
   localparam int unsigned RA_POL    = 8;
   localparam int unsigned NUM_TIM   = 4;

   // bit positions
   localparam int unsigned BP_ENABLE = 31;
   localparam int unsigned BP_VB_EN  = 31;
   localparam int unsigned BP_LN_EN  = 30;
   localparam int unsigned BP_VB_FLG = 15;
   localparam int unsigned BP_LN_FLG = 14;
   localparam int unsigned BP_HS_INV = 25;
   localparam int unsigned BP_VS_INV = 24;
   localparam int unsigned BP_DLY    = 4;

   typedef enum logic [1:0] {
      TG_IDLE  = 2'd0,
      TG_DELAY = 2'd1,
      TG_RUN   = 2'd2
   } tg_state_e;
endpackage

// File: rtl/lcd_tgen_regs.sv
module lcd_tgen_regs
   import lcd_tgen_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DLY_W  = 5,
   parameter int unsigned LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              vb_set,
   input  logic              ln_set,
   output logic              glob_en,
   output logic              chan_en,
   output logic [DLY_W-1:0]  dly_f,
   output logic [31:0]       act_r,
   output logic [31:0]       hor_r,
   output logic [31:0]       ver_r,
   output logic [31:0]       syw_r,
   output logic              inv_h,
   output logic              inv_v,
   output logic              vb_en,
   output logic              ln_en,
   output logic              vb_flg,
   output logic              ln_flg,
   output logic [LINE_W-1:0] line_num
);
   logic [31:0] tim_q [NUM_TIM];
   logic wr_glob, wr_irq, wr_line, wr_chan, wr_pol;

   assign wr_glob = wr && (addr == ADDR_W'(RA_GLOBAL));
   assign wr_irq  = wr && (addr == ADDR_W'(RA_IRQ));
   assign wr_line = wr && (addr == ADDR_W'(RA_LINE));
   assign wr_chan = wr && (addr == ADDR_W'(RA_CHAN));
   assign wr_pol  = wr && (addr == ADDR_W'(RA_POL));

   // one storage word per timing register
   for (genvar gi = 0; gi < NUM_TIM; gi++) begin : g_tim
      always_ff @(posedge clk) begin
         if (!rst_n)
            tim_q[gi] <= '0;
         else if (wr && (addr == ADDR_W'(RA_TIM0 + gi)))
            tim_q[gi] <= wdata;
      end
   end

   assign act_r = tim_q[0];
   assign hor_r = tim_q[1];
   assign ver_r = tim_q[2];
   assign syw_r = tim_q[3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en  <= 1'b0;
         chan_en  <= 1'b0;
         dly_f    <= '0;
         inv_h    <= 1'b0;
         inv_v    <= 1'b0;
         line_num <= '0;
      end else begin
         if (wr_glob) glob_en <= wdata[BP_ENABLE];
         if (wr_chan) begin
            chan_en <= wdata[BP_ENABLE];
            dly_f   <= wdata[BP_DLY +: DLY_W];
         end
         if (wr_pol) begin
            inv_h <= wdata[BP_HS_INV];
            inv_v <= wdata[BP_VS_INV];
         end
         if (wr_line) line_num <= wdata[LINE_W-1:0];
      end
   end

   // interrupt enables and flags; a set event wins over a clearing write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vb_en  <= 1'b0;
         ln_en  <= 1'b0;
         vb_flg <= 1'b0;
         ln_flg <= 1'b0;
      end else if (wr_irq) begin
         vb_en  <= wdata[BP_VB_EN];
         ln_en  <= wdata[BP_LN_EN];
         vb_flg <= vb_set | (vb_flg & wdata[BP_VB_FLG]);
         ln_flg <= ln_set | (ln_flg & wdata[BP_LN_FLG]);
      end else begin
         vb_flg <= vb_flg | vb_set;
         ln_flg <= ln_flg | ln_set;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(RA_GLOBAL): rdata[BP_ENABLE] = glob_en;
         ADDR_W'(RA_IRQ): begin
            rdata[BP_VB_EN]  = vb_en;
            rdata[BP_LN_EN]  = ln_en;
            rdata[BP_VB_FLG] = vb_flg;
            rdata[BP_LN_FLG] = ln_flg;
         end
         ADDR_W'(RA_LINE): rdata[LINE_W-1:0] = line_num;
         ADDR_W'(RA_CHAN): begin
            rdata[BP_ENABLE]       = chan_en;
            rdata[BP_DLY +: DLY_W] = dly_f;
         end
         ADDR_W'(RA_TIM0 + 0): rdata = tim_q[0];
         ADDR_W'(RA_TIM0 + 1): rdata = tim_q[1];
         ADDR_W'(RA_TIM0 + 2): rdata = tim_q[2];
         ADDR_W'(RA_TIM0 + 3): rdata = tim_q[3];
         ADDR_W'(RA_POL): begin
            rdata[BP_HS_INV] = inv_h;
            rdata[BP_VS_INV] = inv_v;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/lcd_tgen_decode.sv
module lcd_tgen_decode #(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned DLY_W   = 5,
   parameter int unsigned DLY_MAX = 30
) (
   input  logic [31:0]      act_r,
   input  logic [31:0]      hor_r,
   input  logic [31:0]      ver_r,
   input  logic [31:0]      syw_r,
   input  logic [DLY_W-1:0] dly_f,
   output logic [CNT_W-1:0] aw_m1,
   output logic [CNT_W-1:0] ah_m1,
   output logic [CNT_W-1:0] hmax,
   output logic [CNT_W-1:0] hs_beg,
   output logic [CNT_W:0]   hs_end,
   output logic [CNT_W-1:0] vmax,
   output logic [CNT_W-1:0] vs_beg,
   output logic [CNT_W:0]   vs_end,
   output logic [DLY_W-1:0] dly_eff
);
   localparam int unsigned FIELD_MAX = (1 << DLY_W) - 1;

   logic [CNT_W-1:0] hbp_m1, vbp_m1, hsw_m1, vsw_m1, vtot;

   assign aw_m1  = act_r[16 +: CNT_W];
   assign ah_m1  = act_r[0 +: CNT_W];
   assign hmax   = hor_r[16 +: CNT_W];
   assign hbp_m1 = hor_r[0 +: CNT_W];
   assign vtot   = ver_r[17 +: CNT_W];   // half-line count divided by two
   assign vbp_m1 = ver_r[0 +: CNT_W];
   assign hsw_m1 = syw_r[16 +: CNT_W];
   assign vsw_m1 = syw_r[0 +: CNT_W];

   // back porch spans sync start to end of line: start = total - porch
   assign hs_beg = hmax - hbp_m1;
   assign hs_end = {1'b0, hs_beg} + {1'b0, hsw_m1} + (CNT_W+1)'(1);
   assign vmax   = vtot - CNT_W'(1);
   assign vs_beg = vtot - vbp_m1 - CNT_W'(1);
   assign vs_end = {1'b0, vs_beg} + {1'b0, vsw_m1} + (CNT_W+1)'(1);

   if (DLY_MAX >= FIELD_MAX) begin : g_noclamp
      assign dly_eff = dly_f;
   end else begin : g_clamp
      assign dly_eff = (dly_f > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : dly_f;
   end
endmodule

// File: rtl/lcd_tgen_core.sv
module lcd_tgen_core
   import lcd_tgen_pkg::*;
#(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned DLY_W  = 5,
   parameter int unsigned LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CNT_W-1:0]  aw_m1,
   input  logic [CNT_W-1:0]  ah_m1,
   input  logic [CNT_W-1:0]  hmax,
   input  logic [CNT_W-1:0]  hs_beg,
   input  logic [CNT_W:0]    hs_end,
   input  logic [CNT_W-1:0]  vmax,
   input  logic [CNT_W-1:0]  vs_beg,
   input  logic [CNT_W:0]    vs_end,
   input  logic [DLY_W-1:0]  dly_eff,
   input  logic [LINE_W-1:0] line_num,
   input  logic              inv_h,
   input  logic              inv_v,
   output logic [CNT_W-1:0]  pix_x,
   output logic [CNT_W-1:0]  pix_y,
   output logic              de,
   output logic              hsync,
   output logic              vsync,
   output logic              running,
   output logic              vb_set,
   output logic              ln_set
);
   tg_state_e        st;
   logic [CNT_W-1:0] hc, vc, next_vc;
   logic [DLY_W-1:0] dly_q, dcnt;
   // shadow copy, reloaded only at frame start
   logic [CNT_W-1:0] s_aw, s_ah, s_hmax, s_hsb, s_vmax, s_vsb;
   logic [CNT_W:0]   s_hse, s_vse;
   logic line_end, last_dly, frame_end, load_sh, enter_line;

   assign line_end   = (hc == s_hmax);
   assign last_dly   = (dcnt == dly_q - DLY_W'(1));
   assign frame_end  = line_end && (vc == s_vmax);
   assign load_sh    = en && ((st == TG_IDLE) ||
                              (st == TG_DELAY && line_end && last_dly) ||
                              (st == TG_RUN && frame_end));
   assign enter_line = en && ((st == TG_IDLE && dly_eff == '0) ||
                              (st == TG_DELAY && line_end && last_dly) ||
                              (st == TG_RUN && line_end));
   assign next_vc    = (st == TG_RUN && vc != s_vmax) ? vc + CNT_W'(1) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= TG_IDLE;
         hc    <= '0;
         vc    <= '0;
         dcnt  <= '0;
         dly_q <= '0;
      end else if (!en) begin
         st   <= TG_IDLE;
         hc   <= '0;
         vc   <= '0;
         dcnt <= '0;
      end else begin
         case (st)
            TG_IDLE: begin
               hc    <= '0;
               vc    <= '0;
               dcnt  <= '0;
               dly_q <= dly_eff;
               st    <= (dly_eff == '0) ? TG_RUN : TG_DELAY;
            end
            TG_DELAY: begin
               if (line_end) begin
                  hc <= '0;
                  if (last_dly) begin
                     st <= TG_RUN;
                     vc <= '0;
                  end else begin
                     dcnt <= dcnt + DLY_W'(1);
                  end
               end else begin
                  hc <= hc + CNT_W'(1);
               end
            end
            TG_RUN: begin
               if (line_end) begin
                  hc <= '0;
                  vc <= next_vc;
               end else begin
                  hc <= hc + CNT_W'(1);
               end
            end
            default: st <= TG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_aw <= '0; s_ah <= '0; s_hmax <= '0; s_hsb <= '0;
         s_vmax <= '0; s_vsb <= '0; s_hse <= '0; s_vse <= '0;
      end else if (load_sh) begin
         s_aw <= aw_m1; s_ah <= ah_m1; s_hmax <= hmax; s_hsb <= hs_beg;
         s_vmax <= vmax; s_vsb <= vs_beg; s_hse <= hs_end; s_vse <= vs_end;
      end
   end

   assign running = en && (st == TG_RUN);
   assign pix_x   = running ? hc : '0;
   assign pix_y   = running ? vc : '0;
   assign de      = running && (hc <= s_aw) && (vc <= s_ah);
   assign hsync   = inv_h ^ (running && (hc >= s_hsb) && ({1'b0, hc} < s_hse));
   assign vsync   = inv_v ^ (running && (vc >= s_vsb) && ({1'b0, vc} < s_vse));
   assign vb_set  = running && line_end && (vc == s_ah);
   assign ln_set  = enter_line && (32'(next_vc) == 32'(line_num));
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned DLY_W   = 5,
   parameter int unsigned DLY_MAX = 30,
   parameter int unsigned LINE_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [CNT_W-1:0]  pix_x,
   output logic [CNT_W-1:0]  pix_y,
   output logic              vblank_irq,
   output logic              line_irq
);
   if (CNT_W < 2 || CNT_W > 15) begin : g_bad_cnt
      $error("CNT_W must lie in 2..15");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must reach nine registers");
   end
   if (DLY_W + 4 > 16 || DLY_W < 1) begin : g_bad_dly
      $error("delay field must sit in the low half word");
   end
   if (LINE_W < 1 || LINE_W > 16) begin : g_bad_line
      $error("LINE_W must lie in 1..16");
   end

   logic              glob_en, chan_en, inv_h, inv_v;
   logic              vb_en, ln_en, vb_flg, ln_flg, vb_set, ln_set, running;
   logic [DLY_W-1:0]  dly_f, dly_eff;
   logic [31:0]       act_r, hor_r, ver_r, syw_r;
   logic [LINE_W-1:0] line_num;
   logic [CNT_W-1:0]  aw_m1, ah_m1, hmax, hs_beg, vmax, vs_beg;
   logic [CNT_W:0]    hs_end, vs_end;

   lcd_tgen_regs #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .LINE_W(LINE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .vb_set(vb_set), .ln_set(ln_set),
      .glob_en(glob_en), .chan_en(chan_en), .dly_f(dly_f),
      .act_r(act_r), .hor_r(hor_r), .ver_r(ver_r), .syw_r(syw_r),
      .inv_h(inv_h), .inv_v(inv_v), .vb_en(vb_en), .ln_en(ln_en),
      .vb_flg(vb_flg), .ln_flg(ln_flg), .line_num(line_num)
   );

   lcd_tgen_decode #(.CNT_W(CNT_W), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_dec (
      .act_r(act_r), .hor_r(hor_r), .ver_r(ver_r), .syw_r(syw_r), .dly_f(dly_f),
      .aw_m1(aw_m1), .ah_m1(ah_m1), .hmax(hmax), .hs_beg(hs_beg), .hs_end(hs_end),
      .vmax(vmax), .vs_beg(vs_beg), .vs_end(vs_end), .dly_eff(dly_eff)
   );

   lcd_tgen_core #(.CNT_W(CNT_W), .DLY_W(DLY_W), .LINE_W(LINE_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(glob_en && chan_en),
      .aw_m1(aw_m1), .ah_m1(ah_m1), .hmax(hmax), .hs_beg(hs_beg), .hs_end(hs_end),
      .vmax(vmax), .vs_beg(vs_beg), .vs_end(vs_end), .dly_eff(dly_eff),
      .line_num(line_num), .inv_h(inv_h), .inv_v(inv_v),
      .pix_x(pix_x), .pix_y(pix_y), .de(de), .hsync(hsync), .vsync(vsync),
      .running(running), .vb_set(vb_set), .ln_set(ln_set)
   );

   assign vblank_irq = vb_flg && vb_en;
   assign line_irq   = ln_flg && ln_en;
endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk
   import lcd_tgen_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned LINE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              glob_en,
   input logic              chan_en,
   input logic              vb_en,
   input logic              vb_flg,
   input logic              ln_flg,
   input logic              vb_set,
   input logic [LINE_W-1:0] line_num,
   input logic              running,
   input logic              de,
   input logic [CNT_W-1:0]  pix_x,
   input logic [CNT_W-1:0]  pix_y,
   input logic              vblank_irq
);
   // R2
   pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && pix_x != '0) |-> (pix_x == $past(pix_x) + CNT_W'(1)));

   // R2
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && pix_x != '0) |-> (pix_y == $past(pix_y)));

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(glob_en && chan_en) |-> (!de && pix_x == '0 && pix_y == '0));

   // R7
   vb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vb_flg) |-> (pix_x == '0));

   // R10
   ln_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ln_flg) |-> (pix_x == '0 && 32'(pix_y) == 32'(line_num)));

   // R7
   vb_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_irq |-> vb_en);

   // R8
   vb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(RA_IRQ) && !bus_wdata[BP_VB_FLG] && !vb_set)
      |=> !vb_flg);
endmodule

bind lcd_tgen lcd_tgen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .glob_en(glob_en), .chan_en(chan_en), .vb_en(vb_en), .vb_flg(vb_flg), .ln_flg(ln_flg),
   .vb_set(vb_set), .line_num(line_num), .running(running), .de(de),
   .pix_x(pix_x), .pix_y(pix_y), .vblank_irq(vblank_irq)
);

// File: tb/lcd_tgen_tb.sv
module lcd_tgen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        hsync, vsync, de, vblank_irq, line_irq;
   logic [11:0] pix_x, pix_y;

   int total = 0;
   int bad = 0;
   int c = 0;
   bit done = 0;

   // configuration under test
   int W, htot, hbp, hsw, H, vtot, vbp, vsw, dly, L;
   bit invh, invv, vben, lnen;

   always #5 clk = ~clk;

   lcd_tgen u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync), .vsync(vsync),
      .de(de), .pix_x(pix_x), .pix_y(pix_y), .vblank_irq(vblank_irq), .line_irq(line_irq)
   );

   task automatic check(input bit ok, input string msg);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      c++;
   endtask

   task automatic wr_reg(input int a, input logic [31:0] d);
      @(negedge clk); c++;
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk); c++;
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input int a, output logic [31:0] d);
      bus_addr = 4'(a);
      #1 d = bus_rdata;
   endtask

   // expected outputs for state index cc after the enabling write
   task automatic model(input int cc, output bit e_de, output bit e_hs, output bit e_vs,
                        output bit e_vb, output bit e_ln, output int e_x, output int e_y);
      int t;
      t = cc - 1 - dly * htot;
      if (t < 0) begin
         e_de = 0; e_hs = invh; e_vs = invv; e_vb = 0; e_ln = 0; e_x = 0; e_y = 0;
      end else begin
         e_x  = t % htot;
         e_y  = (t / htot) % vtot;
         e_de = (e_x < W) && (e_y < H);
         e_hs = invh ^ ((e_x >= htot - hbp) && (e_x < htot - hbp + hsw));
         e_vs = invv ^ ((e_y >= vtot - vbp) && (e_y < vtot - vbp + vsw));
         e_vb = (t >= H * htot);
         e_ln = (t >= L * htot);
      end
   endtask

   task automatic program_and_start();
      int dfield;
      dfield = dly;
      wr_reg(3, 32'h0);
      wr_reg(1, {vben, lnen, 30'h0});
      wr_reg(4, {16'(W - 1), 16'(H - 1)});
      wr_reg(5, {16'(htot - 1), 16'(hbp - 1)});
      wr_reg(6, {16'(2 * vtot), 16'(vbp - 1)});
      wr_reg(7, {16'(hsw - 1), 16'(vsw - 1)});
      wr_reg(8, {6'h0, invh, invv, 24'h0});
      wr_reg(2, 32'(L));
      wr_reg(0, 32'h8000_0000);
      wr_reg(3, 32'h8000_0000 | 32'(dfield << 4));
      c = 0;
   endtask

   task automatic run_random(input int idx);
      int n, tm, fm;
      bit e_de, e_hs, e_vs, e_vb, e_ln;
      int e_x, e_y;
      string tmsg, fmsg;
      tm = 0; fm = 0; tmsg = ""; fmsg = "";
      program_and_start();
      n = 1 + dly * htot + 2 * htot * vtot + 3;
      for (int k = 0; k < n; k++) begin
         tick();
         model(c, e_de, e_hs, e_vs, e_vb, e_ln, e_x, e_y);
         if (de !== e_de || hsync !== e_hs || vsync !== e_vs ||
             int'(pix_x) != e_x || int'(pix_y) != e_y) begin
            if (tm == 0)
               tmsg = $sformatf("c=%0d act de/hs/vs/x/y=%0b%0b%0b/%0d/%0d exp %0b%0b%0b/%0d/%0d",
                                c, de, hsync, vsync, pix_x, pix_y, e_de, e_hs, e_vs, e_x, e_y);
            tm++;
         end
         if (vblank_irq !== (e_vb & vben) || line_irq !== (e_ln & lnen)) begin
            if (fm == 0)
               fmsg = $sformatf("c=%0d act vbirq/lnirq=%0b/%0b exp %0b/%0b",
                                c, vblank_irq, line_irq, e_vb & vben, e_ln & lnen);
            fm++;
         end
      end
      check(tm == 0, $sformatf("R2 R3 R4 R5 R6 R9 cfg %0d timing: %s", idx, tmsg));
      check(fm == 0, $sformatf("R7 R10 cfg %0d irq: %s", idx, fmsg));
   endtask

   initial begin
      int ex_int;
      logic [31:0] rv;
      begin : watchdog
         fork
            begin
               repeat (200000) @(posedge clk);
               if (!done) begin
                  total++; bad++;
                  $display("FAIL watchdog expired");
                  $display("test done: total=%0d bad=%0d", total, bad);
                  $finish;
               end
            end
         join_none
      end

      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(hsync === 0 && vsync === 0 && de === 0 && pix_x === 0 && pix_y === 0,
            $sformatf("R1 outputs act hs=%0b vs=%0b de=%0b x=%0d y=%0d exp 0", hsync, vsync, de, pix_x, pix_y));
      check(vblank_irq === 0 && line_irq === 0,
            $sformatf("R1 irq act %0b%0b exp 00", vblank_irq, line_irq));
      rd_reg(1, rv);
      check(rv === 32'h0, $sformatf("R1 irq reg act %h exp 0", rv));
      rd_reg(3, rv);
      check(rv === 32'h0, $sformatf("R1 chan reg act %h exp 0", rv));

      // random configurations
      for (int i = 0; i < 6; i++) begin
         W    = 2 + int'($urandom % 6);
         hsw  = 1 + int'($urandom % 3);
         hbp  = hsw + int'($urandom % 3);
         htot = W + hbp + 1 + int'($urandom % 2);
         H    = 2 + int'($urandom % 3);
         vsw  = 1 + int'($urandom % 2);
         vbp  = vsw + int'($urandom % 2);
         vtot = H + vbp + 1 + int'($urandom % 2);
         dly  = int'($urandom % 4);
         L    = int'($urandom % 32'(vtot));
         invh = 1'($urandom); invv = 1'($urandom);
         vben = 1'($urandom); lnen = 1'($urandom);
         run_random(i);
      end

      // directed: mid-frame reprogramming, flags, write-to-clear
      W = 4; htot = 10; hbp = 3; hsw = 1; H = 2; vtot = 4; vbp = 1; vsw = 1;
      dly = 0; L = 1; invh = 0; invv = 0; vben = 1; lnen = 1;
      program_and_start();
      repeat (4) tick();
      wr_reg(5, {16'd13, 16'd2});            // line total 14 from next frame
      while (c < 25) tick();
      rd_reg(1, rv);
      check(rv === 32'hC000_C000, $sformatf("R7 R10 flags set act %h exp c000c000", rv));
      while (c < 40) tick();
      check(pix_x == 9 && pix_y == 3, $sformatf("R11 old frame end act %0d,%0d exp 9,3", pix_x, pix_y));
      tick();
      check(pix_x == 0 && pix_y == 0, $sformatf("R11 frame start act %0d,%0d exp 0,0", pix_x, pix_y));
      while (c < 54) tick();
      check(pix_x == 13 && pix_y == 0, $sformatf("R11 new line end act %0d,%0d exp 13,0", pix_x, pix_y));
      tick();
      check(pix_x == 0 && pix_y == 1, $sformatf("R11 new line wrap act %0d,%0d exp 0,1", pix_x, pix_y));
      wr_reg(1, 32'hC000_8000);              // keep vblank flag, clear line flag
      rd_reg(1, rv);
      check(rv === 32'hC000_8000, $sformatf("R8 partial clear act %h exp c0008000", rv));
      check(vblank_irq === 1 && line_irq === 0,
            $sformatf("R8 irq after partial clear act %0b%0b exp 10", vblank_irq, line_irq));
      wr_reg(1, 32'hC000_0000);
      rd_reg(1, rv);
      check(rv === 32'hC000_0000 && vblank_irq === 0,
            $sformatf("R8 full clear act %h irq %0b exp c0000000 0", rv, vblank_irq));

      // directed: clamp of delay field 31 to 30 lines, then immediate stop
      W = 4; htot = 8; hbp = 2; hsw = 1; H = 2; vtot = 4; vbp = 1; vsw = 1;
      dly = 31; L = 3; invh = 1; invv = 1; vben = 0; lnen = 0;
      program_and_start();
      while (c < 240) tick();
      check(de === 0 && hsync === 1 && vsync === 1 && pix_x == 0,
            $sformatf("R6 R9 still waiting act de=%0b hs=%0b vs=%0b exp 0 1 1", de, hsync, vsync));
      tick();
      check(de === 1 && pix_x == 0 && pix_y == 0,
            $sformatf("R6 start after 30 lines act de=%0b x=%0d exp de=1 x=0", de, pix_x));
      wr_reg(3, 32'h0);
      check(de === 0 && pix_x == 0 && pix_y == 0 && hsync === 1 && vsync === 1,
            $sformatf("R12 stop act de=%0b x=%0d hs=%0b vs=%0b exp 0 0 1 1", de, pix_x, hsync, vsync));
      tick();
      check(de === 0 && pix_x == 0, $sformatf("R12 stays stopped act de=%0b x=%0d exp 0 0", de, pix_x));

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule